// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits in front of a two-port shared memory array and resolves address collisions. Each port has an enable, a write strobe, an address and write data. When both ports are enabled on the same address, one port is granted and a busy flag goes to the other. Only writes that survive this arbitration are passed on to the array as commit strobes, together with their address and data.

A role input picks how busy is obtained. As a master, the block arbitrates locally and drives its busy outputs with the result. As a slave, its busy outputs stay low and the busy inputs, supplied by a master device, decide which writes are suppressed. Several devices can therefore be cascaded to form a wider word, and every slice makes the same decision. Every write passes through a two-stage pipeline, whatever the role. The decision stage runs in the cycle after the request, so a slave's incoming busy has settled before any write is committed.

Top module: `dual_port_contend_arb`

## Requirements
- R1: A contention exists only when both port enables are high and both addresses are equal. In any cycle without contention, neither busy output is raised on the following cycle.
- R2: In master role (role_master = 1), a contention cycle produces exactly one high busy output, registered and visible in the next cycle.
- R3: If one port was already enabled on the contested address in the previous cycle and the other port was not, the earlier port wins and busy goes to the later port.
- R4: If both ports arrive at the contested address in the same cycle, the left port wins and r_busy_out is raised.
- R5: The winner keeps the grant for as long as contention continues. Busy returns low in the cycle after the contention ends, for example when the winner drops its enable or moves to another address.
- R6: A write request (enable and write strobe both high) appears at the commit outputs two cycles later, with its address and data. In master role, it is suppressed when that port's busy output is high in the cycle after the request.
- R7: In slave role (role_master = 0), both busy outputs are held low, and the local arbitration result has no effect on any output.
- R8: In slave role, a write is committed only when that port's busy input is low in the cycle after the request.
- R9: In master role, the busy inputs have no effect on committed writes.
- R10: Two reads of the same address still raise busy under the contention rule, and a read never produces a commit.
- R11: A synchronous active-high reset clears both busy outputs and both commit strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| role_master | input | 1 | 1 = master (local arbitration), 0 = slave (external busy) |
| l_en | input | 1 | Left port enable |
| l_we | input | 1 | Left port write strobe |
| l_addr | input | AW | Left port address |
| l_wdata | input | DW | Left port write data |
| r_en | input | 1 | Right port enable |
| r_we | input | 1 | Right port write strobe |
| r_addr | input | AW | Right port address |
| r_wdata | input | DW | Right port write data |
| l_busy_in | input | 1 | External busy for the left port (slave role) |
| r_busy_in | input | 1 | External busy for the right port (slave role) |
| l_busy_out | output | 1 | Busy for the left port (master role) |
| r_busy_out | output | 1 | Busy for the right port (master role) |
| l_wr_go | output | 1 | Left write commit strobe to the array |
| l_wr_addr | output | AW | Left committed write address |
| l_wr_data | output | DW | Left committed write data |
| r_wr_go | output | 1 | Right write commit strobe to the array |
| r_wr_addr | output | AW | Right committed write address |
| r_wr_data | output | DW | Right committed write data |

## Verification
Several rules are checked every cycle by the assertions. Busy may only follow a contention, and one in master role yields exactly one busy line. The busy outputs stay low in slave role, and a raised busy, local or external, blocks the commit that depends on it. Every commit must trace back to a write request two cycles earlier. Which port wins depends on the arrival history, so the earlier-arrival rule, the left-wins tie rule, grant retention and release timing are shown only by the bench's directed scenarios. The same holds for the committed address and data values and for the insensitivity of a master to its busy inputs.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
  localparam int unsigned NPORT = 2;
  localparam int unsigned LEFT  = 0;
  localparam int unsigned RIGHT = 1;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'b00,
    OWN_LEFT  = 2'b01,
    OWN_RIGHT = 2'b10
  } owner_e;
endpackage

// File: rtl/dpa_order.sv
// Arrival tracking and grant decision for the two ports.
module dpa_order
  import dpa_pkg::*;
#(
  parameter int unsigned AW = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      role_master,
  input  logic [NPORT-1:0]          en,
  input  logic [NPORT-1:0][AW-1:0]  addr,
  output logic [NPORT-1:0]          busy_loc
);
  logic [NPORT-1:0]         prev_en;
  logic [NPORT-1:0][AW-1:0] prev_addr;
  logic [NPORT-1:0]         seen;
  logic                     match;
  owner_e                   own_q, own_n;

  // per-port history: was this port already on this address last cycle
  for (genvar i = 0; i < NPORT; i++) begin : g_hist
    always_ff @(posedge clk) begin
      if (rst) begin
        prev_en[i]   <= 1'b0;
        prev_addr[i] <= '0;
      end else begin
        prev_en[i]   <= en[i];
        prev_addr[i] <= addr[i];
      end
    end
    assign seen[i] = prev_en[i] && (prev_addr[i] == addr[i]);
  end

  assign match = en[LEFT] && en[RIGHT] && (addr[LEFT] == addr[RIGHT]);

  always_comb begin
    own_n = OWN_NONE;
    if (match) begin
      if (own_q == OWN_LEFT && seen[LEFT])
        own_n = OWN_LEFT;
      else if (own_q == OWN_RIGHT && seen[RIGHT])
        own_n = OWN_RIGHT;
      else if (seen[RIGHT] && !seen[LEFT])
        own_n = OWN_RIGHT;
      else
        own_n = OWN_LEFT;   // earlier left, or a same-cycle tie
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q    <= OWN_NONE;
      busy_loc <= '0;
    end else begin
      own_q           <= own_n;
      busy_loc[LEFT]  <= role_master && (own_n == OWN_RIGHT);
      busy_loc[RIGHT] <= role_master && (own_n == OWN_LEFT);
    end
  end
endmodule

// File: rtl/dpa_wr_stage.sv
// Two-stage write path: capture the request, then commit it against the
// busy value that belongs to that request.
module dpa_wr_stage #(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          role_master,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  input  logic          busy_loc,
  input  logic          busy_ext,
  output logic          wr_go,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data
);
  logic          req_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          blocked;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      req_q  <= en && we;
      addr_q <= addr;
      data_q <= data;
    end
  end

  assign blocked = role_master ? busy_loc : busy_ext;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_go   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_go   <= req_q && !blocked;
      wr_addr <= addr_q;
      wr_data <= data_q;
    end
  end
endmodule

// File: rtl/dual_port_contend_arb.sv
module dual_port_contend_arb
  import dpa_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          role_master,
  input  logic          l_en,
  input  logic          l_we,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  input  logic          r_en,
  input  logic          r_we,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  input  logic          l_busy_in,
  input  logic          r_busy_in,
  output logic          l_busy_out,
  output logic          r_busy_out,
  output logic          l_wr_go,
  output logic [AW-1:0] l_wr_addr,
  output logic [DW-1:0] l_wr_data,
  output logic          r_wr_go,
  output logic [AW-1:0] r_wr_addr,
  output logic [DW-1:0] r_wr_data
);
  logic [NPORT-1:0]         en_v, we_v, bext_v, busy_v, go_v;
  logic [NPORT-1:0][AW-1:0] addr_v, waddr_v;
  logic [NPORT-1:0][DW-1:0] data_v, wdata_v;

  assign en_v   = {r_en, l_en};
  assign we_v   = {r_we, l_we};
  assign bext_v = {r_busy_in, l_busy_in};
  assign addr_v = {r_addr, l_addr};
  assign data_v = {r_wdata, l_wdata};

  dpa_order #(.AW(AW)) u_order (
    .clk         (clk),
    .rst         (rst),
    .role_master (role_master),
    .en          (en_v),
    .addr        (addr_v),
    .busy_loc    (busy_v)
  );

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    dpa_wr_stage #(.AW(AW), .DW(DW)) u_wr (
      .clk         (clk),
      .rst         (rst),
      .role_master (role_master),
      .en          (en_v[i]),
      .we          (we_v[i]),
      .addr        (addr_v[i]),
      .data        (data_v[i]),
      .busy_loc    (busy_v[i]),
      .busy_ext    (bext_v[i]),
      .wr_go       (go_v[i]),
      .wr_addr     (waddr_v[i]),
      .wr_data     (wdata_v[i])
    );
  end

  assign l_busy_out = busy_v[LEFT];
  assign r_busy_out = busy_v[RIGHT];
  assign l_wr_go    = go_v[LEFT];
  assign r_wr_go    = go_v[RIGHT];
  assign l_wr_addr  = waddr_v[LEFT];
  assign r_wr_addr  = waddr_v[RIGHT];
  assign l_wr_data  = wdata_v[LEFT];
  assign r_wr_data  = wdata_v[RIGHT];
endmodule

// File: rtl/dpa_checker.sv
module dpa_checker #(
  parameter int unsigned AW = 12
) (
  input logic          clk,
  input logic          rst,
  input logic          role_master,
  input logic          l_en,
  input logic          l_we,
  input logic [AW-1:0] l_addr,
  input logic          r_en,
  input logic          r_we,
  input logic [AW-1:0] r_addr,
  input logic          l_busy_in,
  input logic          r_busy_in,
  input logic          l_busy_out,
  input logic          r_busy_out,
  input logic          l_wr_go,
  input logic          r_wr_go
);
  logic hit;
  assign hit = l_en && r_en && (l_addr == r_addr);

  AST_NO_HIT_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    !hit |=> (!l_busy_out && !r_busy_out)); // R1
  AST_HIT_ONE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (role_master && hit) |=> ($countones({l_busy_out, r_busy_out}) == 1)); // R2
  AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !role_master |=> (!l_busy_out && !r_busy_out)); // R7
  AST_MASTER_GATE_L: assert property (@(posedge clk) disable iff (rst)
    (role_master && l_busy_out) |=> !l_wr_go); // R6
  AST_MASTER_GATE_R: assert property (@(posedge clk) disable iff (rst)
    (role_master && r_busy_out) |=> !r_wr_go); // R6
  AST_SLAVE_GATE_L: assert property (@(posedge clk) disable iff (rst)
    (!role_master && l_busy_in) |=> !l_wr_go); // R8
  AST_SLAVE_GATE_R: assert property (@(posedge clk) disable iff (rst)
    (!role_master && r_busy_in) |=> !r_wr_go); // R8
  AST_COMMIT_SRC_L: assert property (@(posedge clk) disable iff (rst)
    l_wr_go |-> $past(l_en && l_we, 2)); // R10
  AST_COMMIT_SRC_R: assert property (@(posedge clk) disable iff (rst)
    r_wr_go |-> $past(r_en && r_we, 2)); // R10
endmodule

bind dual_port_contend_arb dpa_checker #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .role_master (role_master),
  .l_en        (l_en),
  .l_we        (l_we),
  .l_addr      (l_addr),
  .r_en        (r_en),
  .r_we        (r_we),
  .r_addr      (r_addr),
  .l_busy_in   (l_busy_in),
  .r_busy_in   (r_busy_in),
  .l_busy_out  (l_busy_out),
  .r_busy_out  (r_busy_out),
  .l_wr_go     (l_wr_go),
  .r_wr_go     (r_wr_go)
);

// File: tb/sim_dual_port_contend_arb.sv
`timescale 1ns/1ps
module sim_dual_port_contend_arb;
  localparam int AW = 12;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic          role_master;
  logic          l_en, l_we, r_en, r_we;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata;
  logic          l_busy_in, r_busy_in;
  logic          l_busy_out, r_busy_out;
  logic          l_wr_go, r_wr_go;
  logic [AW-1:0] l_wr_addr, r_wr_addr;
  logic [DW-1:0] l_wr_data, r_wr_data;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dual_port_contend_arb #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .role_master(role_master),
    .l_en(l_en), .l_we(l_we), .l_addr(l_addr), .l_wdata(l_wdata),
    .r_en(r_en), .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata),
    .l_busy_in(l_busy_in), .r_busy_in(r_busy_in),
    .l_busy_out(l_busy_out), .r_busy_out(r_busy_out),
    .l_wr_go(l_wr_go), .l_wr_addr(l_wr_addr), .l_wr_data(l_wr_data),
    .r_wr_go(r_wr_go), .r_wr_addr(r_wr_addr), .r_wr_data(r_wr_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    l_en = 0; l_we = 0; r_en = 0; r_we = 0;
    l_busy_in = 0; r_busy_in = 0;
  endtask

  task automatic setl(input logic en, input logic we,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_en = en; l_we = we; l_addr = a; l_wdata = d;
  endtask

  task automatic setr(input logic en, input logic we,
                      input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_en = en; r_we = we; r_addr = a; r_wdata = d;
  endtask

  task automatic flush();
    idle(); tick(); tick(); tick();
  endtask

  task automatic t_reset();
    rst = 1; role_master = 1; idle();
    l_addr = 0; r_addr = 0; l_wdata = 0; r_wdata = 0;
    tick(); tick();
    chk("R11", "l_busy_out", l_busy_out, 0);
    chk("R11", "r_busy_out", r_busy_out, 0);
    chk("R11", "l_wr_go", l_wr_go, 0);
    chk("R11", "r_wr_go", r_wr_go, 0);
    rst = 0; tick();
  endtask

  task automatic t_left_first();
    flush();
    setl(1, 0, 5, 0); tick();
    chk("R1", "busy with one port", {l_busy_out, r_busy_out}, 0);
    setl(1, 1, 5, 16'h0011); setr(1, 1, 5, 16'h0022); tick();
    chk("R3", "r_busy_out", r_busy_out, 1);
    chk("R2", "l_busy_out", l_busy_out, 0);
    idle(); tick();
    chk("R6", "l_wr_go", l_wr_go, 1);
    chk("R6", "l_wr_addr", l_wr_addr, 5);
    chk("R6", "l_wr_data", l_wr_data, 16'h0011);
    chk("R6", "r_wr_go loser", r_wr_go, 0);
    chk("R5", "r_busy_out released", r_busy_out, 0);
  endtask

  task automatic t_right_first();
    flush();
    setr(1, 0, 8, 0); tick();
    setl(1, 1, 8, 16'h0033); setr(1, 1, 8, 16'h0044); tick();
    chk("R3", "l_busy_out", l_busy_out, 1);
    chk("R2", "r_busy_out", r_busy_out, 0);
    idle(); tick();
    chk("R6", "r_wr_go", r_wr_go, 1);
    chk("R6", "r_wr_data", r_wr_data, 16'h0044);
    chk("R6", "l_wr_go loser", l_wr_go, 0);
  endtask

  task automatic t_tie();
    flush();
    setl(1, 1, 7, 16'h0055); setr(1, 1, 7, 16'h0066); tick();
    chk("R4", "r_busy_out", r_busy_out, 1);
    chk("R4", "l_busy_out", l_busy_out, 0);
    idle(); tick();
    chk("R4", "l_wr_go", l_wr_go, 1);
    chk("R4", "r_wr_go", r_wr_go, 0);
  endtask

  task automatic t_distinct();
    flush();
    setl(1, 1, 3, 16'h0A0A); setr(1, 1, 4, 16'h0B0B); tick();
    chk("R1", "busy on distinct addrs", {l_busy_out, r_busy_out}, 0);
    idle(); tick();
    chk("R1", "both commits", {l_wr_go, r_wr_go}, 2'b11);
    chk("R6", "r_wr_addr", r_wr_addr, 4);
    chk("R6", "l_wr_data", l_wr_data, 16'h0A0A);
  endtask

  task automatic t_hold_release();
    flush();
    setl(1, 0, 9, 0); setr(1, 0, 9, 0); tick();
    tick(); tick();
    chk("R5", "r_busy_out held", r_busy_out, 1);
    chk("R5", "l_busy_out held", l_busy_out, 0);
    setl(1, 0, 10, 0); tick();
    chk("R5", "busy after winner moved", {l_busy_out, r_busy_out}, 0);
    setl(1, 0, 9, 0); tick();
    chk("R3", "l_busy_out on late return", l_busy_out, 1);
    chk("R3", "r_busy_out on late return", r_busy_out, 0);
  endtask

  task automatic t_read_read();
    flush();
    setl(1, 0, 12, 0); setr(1, 0, 12, 0); tick();
    chk("R10", "r_busy_out on reads", r_busy_out, 1);
    idle(); tick();
    chk("R10", "no commit on reads", {l_wr_go, r_wr_go}, 0);
  endtask

  task automatic t_master_ignores_in();
    flush();
    setl(1, 1, 20, 16'h0C0C); tick();
    idle(); l_busy_in = 1; r_busy_in = 1; tick();
    chk("R9", "l_wr_go with busy_in high", l_wr_go, 1);
  endtask

  task automatic t_slave();
    role_master = 0; flush();
    setl(1, 1, 3, 16'h0101); setr(1, 1, 3, 16'h0202); tick();
    chk("R7", "busy outputs in slave", {l_busy_out, r_busy_out}, 0);
    idle(); r_busy_in = 1; tick();
    chk("R8", "l_wr_go", l_wr_go, 1);
    chk("R8", "r_wr_go gated", r_wr_go, 0);
    idle(); setl(1, 1, 30, 16'h0303); tick();
    idle(); l_busy_in = 1; tick();
    chk("R8", "l_wr_go gated alone", l_wr_go, 0);
    idle(); setl(1, 1, 30, 16'h0404); tick();
    idle(); tick();
    chk("R8", "l_wr_go free", l_wr_go, 1);
    chk("R7", "l_wr_data", l_wr_data, 16'h0404);
    role_master = 1; flush();
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_left_first();
    t_right_first();
    t_tie();
    t_distinct();
    t_hold_release();
    t_read_read();
    t_master_ignores_in();
    t_slave();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule